// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Kick Handshake

This block turns a free-running clock into a one-cycle clock-enable stream whose average rate is the input rate scaled by `mult/32`, then further divided by a fixed integer prescaler. The fractional step uses pulse swallowing. A 6-bit accumulator adds `mult` on every cycle. Each time the sum reaches 32 it wraps and emits an enable. The prescaler then passes one of every `FIXED_DIV` such enables.

Software programs a 5-bit ratio field, encoded inverted so that `mult = 32 - field`. The write goes through a small register port into a shadow copy. It reaches the divider only after software sets a kick flag. The hardware moves the shadow value into the active ratio at the next accumulator wrap, so no shortened or stretched period is ever produced. It then drops the kick flag on the following cycle. Software polls the flag to learn when the new rate holds. A ratio write that arrives while a change is still pending is refused, and the port reports it as busy.

The register that holds the ratio field (`FIELD_REG`) and its bit offset (`FIELD_LSB`) are per-instance parameters. The field may share the control register with the kick flag, or it may sit in a separate auxiliary register.

Top module: `frac_clk_div`

## Requirements
- R1: After reset the kick flag (bit 31 of register 0) reads 0. The ratio field reads 0. The output runs at full fractional rate, giving 32·N enables in every window of 32·FIXED_DIV·N cycles.
- R2: For an active field value f, the multiplier is 32 − f. Any window of 32·FIXED_DIV·N consecutive cycles holds exactly (32 − f)·N enables on `clk_en`, for every f from 0 to 31.
- R3: A write of the ratio field updates only the shadow copy. It reads back at bits [FIELD_LSB+4:FIELD_LSB] of register FIELD_REG, and the output rate stays unchanged until a kick.
- R4: Writing register 0 with bit 31 = 1 sets the kick flag, which reads 1 from the next cycle on. Writing register 0 with bit 31 = 0 leaves the flag at 0.
- R5: The shadow ratio becomes active only on a cycle where the accumulator wraps. The kick flag clears on the cycle after that transfer, and it stays high for no more than 33 consecutive cycles.
- R6: A write to register FIELD_REG while the kick flag is 1 raises `wr_busy` in that cycle. The write leaves both the shadow and the active ratio unchanged.
- R7: With FIXED_DIV ≥ 2, `clk_en` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 = control (kick at bit 31), 1 = auxiliary |
| wr_data | input | 32 | Write data |
| wr_busy | output | 1 | High when the current write is refused because a change is pending |
| rd_addr | input | 1 | Read address, same map as the write address |
| rd_data | output | 32 | Combinational read data |
| clk_en | output | 1 | Registered one-cycle clock-enable pulse stream |

## Verification
On every cycle the bound checker enforces four properties. The active ratio moves only on an accumulator wrap while a kick is pending. The kick flag falls only after a transfer and never outlives its bound. A refused write leaves the shadow untouched. Enables keep their minimum spacing when prescaling is used. The exact enable count per window, for each of the 32 field values, can only be shown by the bench's long counting runs. The same holds for the fact that a refused ratio never reaches the output, and for the readback placement of the field.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    localparam int REG_W    = 32;
    localparam int FIELD_W  = 5;
    localparam int MULT_W   = FIELD_W + 1;
    localparam int ACC_W    = FIELD_W + 1;
    localparam int KICK_BIT = REG_W - 1;
    localparam logic [MULT_W-1:0] FULL_SCALE = MULT_W'(1 << FIELD_W);

    typedef logic [FIELD_W-1:0] ratio_t;
    typedef logic [MULT_W-1:0]  mult_t;
    typedef logic [ACC_W-1:0]   acc_t;

    typedef struct packed {
        ratio_t shadow;
        ratio_t active;
        logic   kick;
        logic   xfer;
    } ctl_state_t;

    // inverted encoding: field 0 -> 32/32, field 31 -> 1/32
    function automatic mult_t field_to_mult(ratio_t f);
        return FULL_SCALE - {1'b0, f};
    endfunction
endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
    import fcd_pkg::*;
#(
    parameter bit FIELD_REG = 1'b1,
    parameter int FIELD_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic             wr_busy,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             wrap_i,
    output logic             kick_o,
    output logic             xfer_o,
    output ratio_t           shadow_o,
    output ratio_t           active_o
);
    ctl_state_t s_d, s_q;
    logic field_wr, kick_wr, busy_d;

    always_comb begin
        s_d      = s_q;
        s_d.xfer = 1'b0;
        busy_d   = 1'b0;
        field_wr = wr_en && (wr_addr == FIELD_REG);
        kick_wr  = wr_en && (wr_addr == 1'b0) && wr_data[KICK_BIT];

        if (field_wr && s_q.kick) begin
            busy_d = 1'b1;
        end else begin
            if (field_wr) s_d.shadow = wr_data[FIELD_LSB +: FIELD_W];
            if (kick_wr)  s_d.kick   = 1'b1;
        end

        if (s_q.xfer) begin
            s_d.kick = 1'b0;
        end else if (wrap_i && s_q.kick) begin
            s_d.active = s_q.shadow;
            s_d.xfer   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == 1'b0)       rd_data[KICK_BIT] = s_q.kick;
        if (rd_addr == FIELD_REG)  rd_data[FIELD_LSB +: FIELD_W] = s_q.shadow;
    end

    assign wr_busy  = busy_d;
    assign kick_o   = s_q.kick;
    assign xfer_o   = s_q.xfer;
    assign shadow_o = s_q.shadow;
    assign active_o = s_q.active;
endmodule

// File: rtl/fcd_accum.sv
module fcd_accum
    import fcd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mult_t mult_i,
    output logic  wrap_o
);
    acc_t acc_d, acc_q;
    acc_t sum;

    always_comb begin
        sum    = acc_q + ACC_W'(mult_i);
        wrap_o = (sum >= ACC_W'(FULL_SCALE));
        acc_d  = wrap_o ? (sum - ACC_W'(FULL_SCALE)) : sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/fcd_prescale.sv
module fcd_prescale #(
    parameter int FIXED_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic en_o
);
    localparam int CNT_W = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FIXED_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
    } pre_state_t;

    pre_state_t p_d, p_q;

    generate
        if (FIXED_DIV == 1) begin : g_pass
            always_comb begin
                p_d     = p_q;
                p_d.cnt = '0;
                p_d.en  = tick_i;
            end
        end else begin : g_count
            always_comb begin
                p_d    = p_q;
                p_d.en = 1'b0;
                if (tick_i) begin
                    if (p_q.cnt == LAST) begin
                        p_d.cnt = '0;
                        p_d.en  = 1'b1;
                    end else begin
                        p_d.cnt = p_q.cnt + 1'b1;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign en_o = p_q.en;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fcd_pkg::*;
#(
    parameter bit FIELD_REG = 1'b1,
    parameter int FIELD_LSB = 8,
    parameter int FIXED_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [31:0] wr_data,
    output logic        wr_busy,
    input  logic        rd_addr,
    output logic [31:0] rd_data,
    output logic        clk_en
);
    logic   kick_w, xfer_w, wrap_w;
    ratio_t shadow_w, active_w;
    mult_t  mult_w;

    fcd_regs #(.FIELD_REG(FIELD_REG), .FIELD_LSB(FIELD_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_busy(wr_busy),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wrap_i(wrap_w), .kick_o(kick_w), .xfer_o(xfer_w),
        .shadow_o(shadow_w), .active_o(active_w)
    );

    assign mult_w = field_to_mult(active_w);

    fcd_accum u_accum (
        .clk(clk), .rst_n(rst_n), .mult_i(mult_w), .wrap_o(wrap_w)
    );

    fcd_prescale #(.FIXED_DIV(FIXED_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_i(wrap_w), .en_o(clk_en)
    );
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
    parameter int FIXED_DIV = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_addr,
    input logic       kick_bit,
    input logic       wr_busy,
    input logic       kick,
    input logic       xfer,
    input logic       wrap,
    input logic [4:0] shadow,
    input logic [4:0] active,
    input logic       clk_en
);
    logic [5:0] kick_age;

    always_ff @(posedge clk) begin
        if (!rst_n)    kick_age <= '0;
        else if (kick) kick_age <= kick_age + 1'b1;
        else           kick_age <= '0;
    end

    p_kick_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && kick_bit) |=> kick);

    p_active_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> $past(wrap && kick));

    p_kick_falls_after_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kick) |-> $past(xfer));

    p_xfer_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !kick);

    p_kick_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_age <= 6'd33);

    p_busy_keeps_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |=> $stable(shadow));

    p_busy_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> kick);

    p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (FIXED_DIV > 1 && clk_en) |=> !clk_en);
endmodule

bind frac_clk_div frac_clk_div_chk #(.FIXED_DIV(FIXED_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .kick_bit(wr_data[31]), .wr_busy(wr_busy), .kick(kick_w), .xfer(xfer_w),
    .wrap(wrap_w), .shadow(shadow_w), .active(active_w), .clk_en(clk_en)
);

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
    localparam int PERIOD = 10;
    localparam int DIV    = 2;
    localparam int LSB    = 8;
    localparam int NWIN   = 2;
    localparam int WIN    = 32 * DIV * NWIN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_busy;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        clk_en;

    int checks = 0;
    int fails  = 0;
    int doubles = 0;
    logic prev_en = 1'b0;
    logic done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    frac_clk_div #(.FIELD_REG(1'b1), .FIELD_LSB(LSB), .FIXED_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_busy(wr_busy), .rd_addr(rd_addr),
        .rd_data(rd_data), .clk_en(clk_en)
    );

    // R7 monitor: count back-to-back enables
    always @(posedge clk) begin
        #1;
        if (rst_n && clk_en && prev_en) doubles++;
        prev_en = clk_en;
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic reg_rd(input logic a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic count_en(output int n);
        n = 0;
        repeat (WIN) begin
            @(posedge clk);
            #1 if (clk_en) n++;
        end
    endtask

    task automatic wait_kick(output int cyc);
        logic [31:0] v;
        cyc = 0;
        reg_rd(1'b0, v);
        while (v[31] && cyc < 100) begin
            cyc++;
            reg_rd(1'b0, v);
        end
    endtask

    task automatic apply(input int f, output int lat);
        reg_wr(1'b1, 32'(f) << LSB);
        reg_wr(1'b0, 32'h8000_0000);
        wait_kick(lat);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n, lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(1'b0, v);
        check("R1 kick at reset", v[31], 0);
        reg_rd(1'b1, v);
        check("R1 field at reset", v, 0);
        count_en(n);
        check("R1 full rate after reset", n, 32 * NWIN);

        // R3 shadow write has no effect on output until kick
        reg_wr(1'b1, 32'(20) << LSB);
        reg_rd(1'b1, v);
        check("R3 shadow readback", v, 32'(20) << LSB);
        reg_rd(1'b0, v);
        check("R3 no kick from field write", v[31], 0);
        count_en(n);
        check("R3 rate unchanged before kick", n, 32 * NWIN);

        // R4 writing 0 to the kick bit does nothing
        reg_wr(1'b0, 32'h0000_0000);
        reg_rd(1'b0, v);
        check("R4 zero write leaves kick clear", v[31], 0);

        // R4/R6 kick then immediate refused write
        reg_wr(1'b1, 32'(30) << LSB);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'b0; wr_data = 32'h8000_0000;
        @(negedge clk);
        wr_addr = 1'b1; wr_data = 32'(5) << LSB; rd_addr = 1'b0;
        #1;
        check("R4 kick reads 1 while pending", rd_data[31], 1);
        check("R6 busy on pending write", wr_busy, 1);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        reg_rd(1'b1, v);
        check("R6 shadow unchanged by refused write", v, 32'(30) << LSB);
        wait_kick(lat);
        check("R5 kick clears within bound", (lat <= 34) ? 1 : 0, 1);
        count_en(n);
        check("R6 refused ratio not applied", n, 2 * NWIN);
        reg_wr(1'b1, 32'(7) << LSB);
        @(negedge clk); #1;
        check("R6 no busy when idle", wr_busy, 0);

        // R2 sweep of every field value
        for (int f = 0; f < 32; f++) begin
            apply(f, lat);
            check($sformatf("R5 kick latency f=%0d", f), (lat <= 34) ? 1 : 0, 1);
            count_en(n);
            check($sformatf("R2 count f=%0d", f), n, (32 - f) * NWIN);
        end

        // R7 spacing with FIXED_DIV >= 2
        check("R7 no back-to-back enables", doubles, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule